// File: doc/BRIEF.md
# Pixel-to-bus serializer

The block takes a stream of pixels of 12, 16, 18 or 24 bits and turns each pixel, or each pair of pixels, into a short sequence of words for a parallel display bus that is 8, 9, 12 or 16 lines wide. Pixels arrive on a valid/ready input. Bus words leave on a valid/ready output that feeds the strobe timer of the bus.

The pixel depth and the bus width together select the packing. When the depth is one, two or three times the line count, every pixel takes that many bus words. When twice the depth is three times the line count, two pixels share three words, and the middle word carries the tail of the first pixel and the head of the second. Bits always leave most significant first.

A frame is started with a pulse that also carries its pixel count. The configuration is captured at that pulse. When the last word of the frame is accepted, the block raises a one-cycle done pulse and goes idle.

Top module: `pix_serializer`

## Requirements
- R1: Depth code `cfg_depth` is 0=12, 1=16, 2=18 and 3=24 bits. Width code `cfg_width` is 0=8, 1=9, 2=12 and 3=16 lines. A depth equal to one, two or three times the line count gives that many words per pixel. A depth whose double is three times the line count gives three words per pixel pair. Any other pairing ignores `start`: no pixel is accepted, no word is sent and no done pulse is raised.
- R2: `start` in the idle state with a nonzero `frame_len` begins a frame of `frame_len` pixels. The depth and width codes are sampled at that edge only.
- R3: In the per-pixel formats, word k of a pixel of B bits on L lines carries pixel bits [B-1-k·L -: L]. For example, 16 bits on 8 lines send bits 15:8 and then 7:0, and 24 bits on 8 lines send 23:16, 15:8 and 7:0.
- R4: In the pair format, the two pixels are joined as {first, second} into 2B bits, and word k carries bits [2B-1-k·L -: L]. With 24 bits on 16 lines this gives first[23:8], then {first[7:0], second[23:16]}, then second[15:0].
- R5: Each word sits in `bus_data[L-1:0]`. The lines above L are zero.
- R6: Input bits above the configured depth have no effect on any word.
- R7: `pix_ready` is high only when no word is pending. It stays low until every word of the current pixel, or pixel pair, has been accepted. `bus_valid` rises only after a pixel handshake.
- R8: While `bus_valid` is high and `bus_ready` is low, `bus_valid` stays high and `bus_data` stays unchanged.
- R9: `frame_done` is high for exactly one cycle, in the cycle after the last word of the frame is accepted. After that the block is idle and `pix_ready` is low.
- R10: In the pair format with an odd pixel count, the last pixel is paired with a zero pixel and still sends three words.
- R11: A `start` pulse, or a change of the configuration codes, during a frame has no effect on that frame. A `start` with `frame_len` zero is ignored.
- R12: After reset, `pix_ready`, `bus_valid` and `frame_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_depth | input | 2 | Pixel depth code |
| cfg_width | input | 2 | Bus line-count code |
| frame_len | input | CNT_W | Pixels in the frame, sampled with start |
| start | input | 1 | Begin a frame |
| pix_valid | input | 1 | Pixel offered |
| pix_ready | output | 1 | Pixel accepted when high together with pix_valid |
| pix_data | input | 24 | Pixel, right-aligned |
| bus_valid | output | 1 | Bus word offered |
| bus_ready | input | 1 | Strobe timer takes the word |
| bus_data | output | 16 | Bus word, right-aligned on the active lines |
| frame_done | output | 1 | One-cycle pulse at the end of the frame |

## Verification
A wrong shift amount or a stale shift register appears on the very next accepted word, as a bit pattern that differs from the reference packing. The scoreboard compares every word, so the error shows within one word of the fault. A wrong remaining-pixel count shows at the end of the frame: the done pulse comes early or late, or too few or too many words leave. A state machine that loses the pairing phase misplaces the middle word of the pair format, which shows within three words.

// File: rtl/pix_serializer.sv
module pix_serializer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cfg_depth,
  input  logic [1:0]       cfg_width,
  input  logic [CNT_W-1:0] frame_len,
  input  logic             start,
  input  logic             pix_valid,
  output logic             pix_ready,
  input  logic [23:0]      pix_data,
  output logic             bus_valid,
  input  logic             bus_ready,
  output logic [15:0]      bus_data,
  output logic             frame_done
);
  localparam int PW = 24;
  localparam int BW = 16;
  localparam int SW = 2 * PW;

  typedef enum logic [1:0] {IDLE, LOAD, SEND} st_t;

  st_t             st;
  logic [CNT_W-1:0] rem;
  logic             got;
  logic [1:0]       cyc, fmt_q, fmt_new;
  logic [SW-1:0]    sh;
  logic [4:0]       nb, nl, nb_q, nl_q;
  logic [5:0]       nb6, nl6;
  logic             fmt_ok, done_q;
  logic [PW-1:0]    pix_left;

  always_comb begin
    case (cfg_depth)
      2'd0: nb = 5'd12;
      2'd1: nb = 5'd16;
      2'd2: nb = 5'd18;
      default: nb = 5'd24;
    endcase
    case (cfg_width)
      2'd0: nl = 5'd8;
      2'd1: nl = 5'd9;
      2'd2: nl = 5'd12;
      default: nl = 5'd16;
    endcase
    nb6 = {1'b0, nb};
    nl6 = {1'b0, nl};
    fmt_ok = 1'b1;
    fmt_new = 2'd0;
    if (nb6 == nl6)                   fmt_new = 2'd0;
    else if (nb6 == nl6 * 6'd2)       fmt_new = 2'd1;
    else if (nb6 == nl6 * 6'd3)       fmt_new = 2'd2;
    else if (nb6 * 6'd2 == nl6 * 6'd3) fmt_new = 2'd3;
    else                              fmt_ok = 1'b0;
  end

  assign pix_left   = pix_data << (5'(PW) - nb_q);
  assign pix_ready  = (st == LOAD);
  assign bus_valid  = (st == SEND);
  assign bus_data   = sh[SW-1 -: BW] >> (5'(BW) - nl_q);
  assign frame_done = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= IDLE;
      rem    <= '0;
      got    <= 1'b0;
      cyc    <= 2'd0;
      sh     <= '0;
      fmt_q  <= 2'd0;
      nb_q   <= 5'd0;
      nl_q   <= 5'd0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        IDLE: if (start && fmt_ok && frame_len != '0) begin
          st    <= LOAD;
          rem   <= frame_len;
          got   <= 1'b0;
          fmt_q <= fmt_new;
          nb_q  <= nb;
          nl_q  <= nl;
        end
        LOAD: if (pix_valid) begin
          rem <= rem - 1'b1;
          if (fmt_q != 2'd3) begin
            sh  <= {pix_left, {PW{1'b0}}};
            cyc <= fmt_q + 2'd1;
            st  <= SEND;
          end else if (!got) begin
            sh <= {pix_left, {PW{1'b0}}};
            if (rem == CNT_W'(1)) begin
              cyc <= 2'd3;
              st  <= SEND;
            end else begin
              got <= 1'b1;
            end
          end else begin
            sh  <= sh | ({pix_left, {PW{1'b0}}} >> nb_q);
            got <= 1'b0;
            cyc <= 2'd3;
            st  <= SEND;
          end
        end
        SEND: if (bus_ready) begin
          sh  <= sh << nl_q;
          cyc <= cyc - 2'd1;
          if (cyc == 2'd1) begin
            if (rem == '0) begin
              st     <= IDLE;
              done_q <= 1'b1;
            end else begin
              st <= LOAD;
            end
          end
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

module pix_serializer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        pix_valid,
  input logic        pix_ready,
  input logic        bus_valid,
  input logic        bus_ready,
  input logic [15:0] bus_data,
  input logic        frame_done
);
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_data));

  assert_word_after_pixel_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_valid) |-> $past(pix_valid && pix_ready));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  assert_done_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> $past(bus_valid && bus_ready));

  assert_ready_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pix_ready) |-> ($past(start) || $past(bus_valid && bus_ready)));
endmodule

bind pix_serializer pix_serializer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .pix_valid(pix_valid),
  .pix_ready(pix_ready), .bus_valid(bus_valid), .bus_ready(bus_ready),
  .bus_data(bus_data), .frame_done(frame_done)
);

// File: tb/pix_serializer_tb.sv
module pix_serializer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_depth = 2'd0, cfg_width = 2'd0;
  logic [15:0] frame_len = 16'd0;
  logic        start = 1'b0, pix_valid = 1'b0, bus_ready = 1'b1;
  logic [23:0] pix_data = 24'd0;
  logic        pix_ready, bus_valid, frame_done;
  logic [15:0] bus_data;

  int checks = 0, errors = 0, done_cnt = 0;
  logic [15:0] expq[$];
  bit stall = 1'b0, done_due = 1'b0, held = 1'b0;
  logic [15:0] held_data = 16'd0;
  string cur_req = "R3";

  always #5 clk = ~clk;

  pix_serializer u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_depth(cfg_depth), .cfg_width(cfg_width),
    .frame_len(frame_len), .start(start), .pix_valid(pix_valid),
    .pix_ready(pix_ready), .pix_data(pix_data), .bus_valid(bus_valid),
    .bus_ready(bus_ready), .bus_data(bus_data), .frame_done(frame_done)
  );

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int bits_of(int code);
    case (code) 0: return 12; 1: return 16; 2: return 18; default: return 24; endcase
  endfunction
  function automatic int lines_of(int code);
    case (code) 0: return 8; 1: return 9; 2: return 12; default: return 16; endcase
  endfunction
  function automatic int fmt_of(int b, int l);
    if (b % l == 0 && b / l >= 1 && b / l <= 3) return b / l - 1;
    if ((2 * b) % l == 0 && (2 * b) / l == 3) return 3;
    return -1;
  endfunction

  function automatic void push_words(int b, int l, logic [23:0] p0, logic [23:0] p1, bit pair);
    logic [63:0] tot, m0, m1;
    int n, k;
    m0 = 64'(p0) & ((64'd1 << b) - 1);
    m1 = 64'(p1) & ((64'd1 << b) - 1);
    if (pair) begin tot = (m0 << b) | m1; n = 2 * b; k = 3; end
    else begin tot = m0; n = b; k = b / l; end
    for (int i = 0; i < k; i++)
      expq.push_back(16'((tot >> (n - (i + 1) * l)) & ((64'd1 << l) - 1)));
  endfunction

  always begin
    @(posedge clk); #1;
    bus_ready = stall ? (($urandom % 3) != 0) : 1'b1;
  end

  always @(negedge clk) if (rst_n) begin
    if (done_due || frame_done) begin
      chk(frame_done == done_due, "R9", "frame_done timing", frame_done, done_due);
      if (frame_done) done_cnt++;
    end
    if (held) chk(bus_valid && bus_data == held_data, "R8", "stalled word changed", bus_data, held_data);
    held = bus_valid && !bus_ready;
    held_data = bus_data;
    if (bus_valid) chk(!pix_ready, "R7", "pix_ready while word pending", pix_ready, 0);
    done_due = 1'b0;
    if (bus_valid && bus_ready) begin
      if (expq.size() == 0) chk(1'b0, cur_req, "unexpected word", bus_data, 0);
      else begin
        logic [15:0] e;
        e = expq.pop_front();
        chk(bus_data == e, cur_req, "bus word", bus_data, e);
        done_due = (expq.size() == 0);
      end
    end
  end

  task automatic pulse_start(int dt, int ln, int n);
    @(posedge clk); #1;
    cfg_depth = 2'(dt); cfg_width = 2'(ln); frame_len = 16'(n); start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
  endtask

  task automatic send_pixel(logic [23:0] p);
    pix_data = p; pix_valid = 1'b1;
    forever begin
      @(negedge clk);
      if (pix_ready) break;
    end
    @(posedge clk); #1;
    pix_valid = 1'b0;
  endtask

  task automatic run_frame(int dt, int ln, int n, logic [23:0] first, string req, bit disturb);
    int b, l, f, d0;
    logic [23:0] px[$];
    b = bits_of(dt); l = lines_of(ln); f = fmt_of(b, l);
    cur_req = req;
    for (int i = 0; i < n; i++) px.push_back(i == 0 ? first : 24'($urandom));
    if (f == 3) begin
      for (int i = 0; i < n; i += 2)
        push_words(b, l, px[i], (i + 1 < n) ? px[i + 1] : 24'd0, 1'b1);
    end else begin
      for (int i = 0; i < n; i++) push_words(b, l, px[i], 24'd0, 1'b0);
    end
    d0 = done_cnt;
    pulse_start(dt, ln, n);
    for (int i = 0; i < n; i++) begin
      send_pixel(px[i]);
      if (disturb && i == 0) begin
        cfg_depth = 2'(3 - dt); cfg_width = 2'(ln ^ 1); frame_len = 16'd7; start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
      end
    end
    while (done_cnt == d0) @(posedge clk);
    repeat (6) @(negedge clk);
    chk(!pix_ready && !bus_valid, "R9", "idle after frame", {pix_ready, bus_valid}, 0);
    chk(expq.size() == 0, req, "words left over", expq.size(), 0);
  endtask

  task automatic idle_check(int dt, int ln, int n, string req);
    int d0;
    d0 = done_cnt;
    pulse_start(dt, ln, n);
    repeat (15) begin
      @(negedge clk);
      chk(!pix_ready && !bus_valid, req, "start not ignored", {pix_ready, bus_valid}, 0);
    end
    chk(done_cnt == d0, req, "done pulse on ignored start", done_cnt - d0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!pix_ready && !bus_valid && !frame_done, "R12", "reset outputs",
        {pix_ready, bus_valid, frame_done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!pix_ready && !bus_valid && !frame_done, "R12", "after reset release",
        {pix_ready, bus_valid, frame_done}, 0);

    run_frame(1, 0, 3, 24'hFFABCD, "R3", 1'b0);
    run_frame(3, 0, 4, 24'h123456, "R3", 1'b0);
    run_frame(0, 2, 5, 24'hFFFABC, "R6", 1'b0);
    run_frame(1, 3, 4, 24'h55AA55, "R5", 1'b0);
    run_frame(2, 1, 4, 24'hC3FFFF, "R5", 1'b0);
    run_frame(3, 2, 3, 24'hA5A5A5, "R3", 1'b0);
    run_frame(3, 3, 4, 24'hABCDEF, "R4", 1'b0);
    run_frame(0, 0, 6, 24'hFFF123, "R4", 1'b0);
    run_frame(2, 2, 4, 24'h3FFFF0, "R4", 1'b0);
    run_frame(3, 3, 3, 24'h010203, "R10", 1'b0);
    run_frame(0, 0, 1, 24'h000ABC, "R10", 1'b0);
    stall = 1'b1;
    run_frame(3, 0, 6, 24'h808080, "R8", 1'b0);
    run_frame(1, 3, 5, 24'h00F00F, "R8", 1'b0);
    run_frame(3, 3, 5, 24'h0F0F0F, "R8", 1'b0);
    run_frame(1, 0, 4, 24'h00BEEF, "R11", 1'b1);
    stall = 1'b0;
    run_frame(2, 1, 3, 24'h2AAAA, "R2", 1'b0);
    idle_check(1, 1, 4, "R1");
    idle_check(0, 3, 4, "R1");
    idle_check(1, 0, 0, "R11");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule